// File: doc/BRIEF.md
# SIMT Divergence and Reconvergence Controller

This block holds the shared program counter and the per-thread enable mask of one warp of lock-step threads. Each issued instruction is reported as one event on a valid/ready input stream. A plain event moves the program counter to the supplied next address. A branch event carries one taken bit per thread together with three addresses: the taken target, the fall-through address and the point where the two paths meet again.

When every enabled thread goes the same way, the warp simply follows that path. When the enabled threads disagree, the block runs the taken threads first and the other threads wait. It saves two frames on an internal stack. One frame holds the not-taken threads and their start address. The other holds the whole pre-branch mask and the meeting address. Each time the program counter lands on the address the current path is waiting for, the block pops one frame. The not-taken threads then run, and after them the full group carries on together. Nested branches are handled in last-in, first-out order.

The event stream follows the usual handshake: an event is consumed in a cycle where both `ev_valid` and `ev_ready` are high. `ev_ready` drops only in cycles where the controller is popping a frame. It depends only on internal state, never on `ev_valid`, and a producer must hold its event stable until it is accepted.

Top module: `simt_recon_ctl`

## Requirements
- R1: After reset the program counter equals START_PC, all mask bits are 1, the error flag is 0, the stack is empty and `ev_ready` is 1.
- R2: An accepted non-branch event (`ev_br`=0) sets the program counter to `ev_fall` on the next cycle and leaves the mask unchanged.
- R3: An accepted branch whose masked taken vector equals the mask sets the program counter to `ev_target`, keeps the mask and pushes nothing.
- R4: An accepted branch whose masked taken vector is zero sets the program counter to `ev_fall`, keeps the mask and pushes nothing.
- R5: Taken bits of disabled threads have no effect: the decision and the new mask use only `ev_taken & mask`.
- R6: An accepted branch whose masked taken vector is neither zero nor equal to the mask, with at least two free stack slots, sets the program counter to `ev_target` and the mask to the masked taken vector on the next cycle.
- R7: When the program counter equals the meeting address of the running path, the next cycle resumes the saved not-taken threads at the saved fall-through address, with the mask equal to the not-taken threads.
- R8: When the not-taken path reaches the meeting address, the next cycle sets the program counter to that address and restores the full pre-branch mask.
- R9: Nested divergences unwind in last-in, first-out order; an inner meeting restores the outer path's mask and the outer meeting address still applies afterwards.
- R10: The stack holds DEPTH (default 8) frames, two per divergence. A divergent branch with fewer than two free slots sets the error flag, pushes nothing, keeps the mask and moves the program counter to `ev_fall`.
- R11: `ev_ready` is 0 exactly in pop cycles; events offered then are not taken, and the pop consumes one stack frame.
- R12: The error flag stays 1 until reset once it has been set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Issue event present |
| ev_ready | output | 1 | Controller can take an event this cycle |
| ev_br | input | 1 | Event is a conditional branch |
| ev_taken | input | NTHR | Per-thread taken bits |
| ev_target | input | PCW | Taken-path address |
| ev_fall | input | PCW | Next sequential / not-taken address |
| ev_reconv | input | PCW | Meeting address of the two branch paths |
| pc | output | PCW | Current warp program counter |
| mask | output | NTHR | Enabled threads |
| err | output | 1 | Sticky stack-overflow flag |

## Verification
The hardest state to reach is a full stack with the overflow rule and the pop order both in play. It needs four nested divergences, each with a distinct meeting address and a taken subset of the mask left by the previous one, followed by a fifth split. The bench builds this chain in a directed sequence and then walks the program counter through each meeting address in turn, checking every restored mask. A randomized phase with a narrow address range makes meeting addresses collide often. This produces back-to-back pops and branches whose target is already their meeting address, and each one is compared against a queue-based model every cycle.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [1:0] {
    BK_UNI_NT = 2'd0,
    BK_UNI_T  = 2'd1,
    BK_SPLIT  = 2'd2
  } br_kind_e;
endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
  import simt_pkg::*;
#(
  parameter int NTHR = 32
) (
  input  logic [NTHR-1:0] taken,
  input  logic [NTHR-1:0] act,
  output logic [NTHR-1:0] t_set,
  output logic [NTHR-1:0] nt_set,
  output br_kind_e        kind
);
  // Disabled threads are cut off before any decision is made.
  always_comb begin
    t_set  = taken & act;
    nt_set = act & ~taken;
    if (t_set == '0)
      kind = BK_UNI_NT;
    else if (t_set == act)
      kind = BK_UNI_T;
    else
      kind = BK_SPLIT;
  end
endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack #(
  parameter int NTHR  = 32,
  parameter int PCW   = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push2,
  input  logic            pop,
  // lower frame: join point with full mask
  input  logic [PCW-1:0]  lo_pc,
  input  logic [NTHR-1:0] lo_mask,
  input  logic [PCW-1:0]  lo_rpc,
  input  logic            lo_rv,
  // upper frame: waiting not-taken path
  input  logic [PCW-1:0]  hi_pc,
  input  logic [NTHR-1:0] hi_mask,
  input  logic [PCW-1:0]  hi_rpc,
  input  logic            hi_rv,
  output logic [PCW-1:0]  top_pc,
  output logic [NTHR-1:0] top_mask,
  output logic [PCW-1:0]  top_rpc,
  output logic            top_rv,
  output logic [CW-1:0]   count,
  output logic            room2
);
  logic [PCW-1:0]  f_pc   [DEPTH];
  logic [NTHR-1:0] f_mask [DEPTH];
  logic [PCW-1:0]  f_rpc  [DEPTH];
  logic            f_rv   [DEPTH];

  logic [CW-1:0] cnt_q;
  logic [IW-1:0] wr_lo, wr_hi, rd_top;

  always_comb begin
    wr_lo  = IW'(cnt_q);
    wr_hi  = IW'(cnt_q + CW'(1));
    rd_top = IW'(cnt_q - CW'(1));
    room2  = (cnt_q + CW'(2)) <= CW'(DEPTH);
    count  = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (push2)
      cnt_q <= cnt_q + CW'(2);
    else if (pop)
      cnt_q <= cnt_q - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push2) begin
      f_pc[wr_lo]   <= lo_pc;
      f_mask[wr_lo] <= lo_mask;
      f_rpc[wr_lo]  <= lo_rpc;
      f_rv[wr_lo]   <= lo_rv;
      f_pc[wr_hi]   <= hi_pc;
      f_mask[wr_hi] <= hi_mask;
      f_rpc[wr_hi]  <= hi_rpc;
      f_rv[wr_hi]   <= hi_rv;
    end
  end

  always_comb begin
    top_pc   = f_pc[rd_top];
    top_mask = f_mask[rd_top];
    top_rpc  = f_rpc[rd_top];
    top_rv   = f_rv[rd_top];
  end
endmodule

// File: rtl/simt_recon_ctl.sv
module simt_recon_ctl
  import simt_pkg::*;
#(
  parameter int          NTHR     = 32,
  parameter int          PCW      = 32,
  parameter int          DEPTH    = 8,
  parameter logic [31:0] START_PC = 32'h0000_0100,
  localparam int         CW       = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  output logic            ev_ready,
  input  logic            ev_br,
  input  logic [NTHR-1:0] ev_taken,
  input  logic [PCW-1:0]  ev_target,
  input  logic [PCW-1:0]  ev_fall,
  input  logic [PCW-1:0]  ev_reconv,
  output logic [PCW-1:0]  pc,
  output logic [NTHR-1:0] mask,
  output logic            err
);
  logic [PCW-1:0]  pc_q;
  logic [NTHR-1:0] mask_q;
  logic [PCW-1:0]  wait_pc_q;   // join address the running path heads for
  logic            wait_vld_q;
  logic            err_q;

  logic [NTHR-1:0] t_set, nt_set;
  br_kind_e        kind;

  logic [PCW-1:0]  top_pc, top_rpc;
  logic [NTHR-1:0] top_mask;
  logic            top_rv;
  logic [CW-1:0]   stk_cnt;
  logic            room2;

  logic join_hit, accept, split, do_push, overflow;

  simt_branch_eval #(.NTHR(NTHR)) u_eval (
    .taken  (ev_taken),
    .act    (mask_q),
    .t_set  (t_set),
    .nt_set (nt_set),
    .kind   (kind)
  );

  always_comb begin
    join_hit = wait_vld_q && (pc_q == wait_pc_q);
    accept   = ev_valid && !join_hit;
    split    = accept && ev_br && (kind == BK_SPLIT);
    do_push  = split && room2;
    overflow = split && !room2;
  end

  simt_recon_stack #(.NTHR(NTHR), .PCW(PCW), .DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push2    (do_push),
    .pop      (join_hit),
    .lo_pc    (ev_reconv),
    .lo_mask  (mask_q),
    .lo_rpc   (wait_pc_q),
    .lo_rv    (wait_vld_q),
    .hi_pc    (ev_fall),
    .hi_mask  (nt_set),
    .hi_rpc   (ev_reconv),
    .hi_rv    (1'b1),
    .top_pc   (top_pc),
    .top_mask (top_mask),
    .top_rpc  (top_rpc),
    .top_rv   (top_rv),
    .count    (stk_cnt),
    .room2    (room2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q       <= PCW'(START_PC);
      mask_q     <= '1;
      wait_pc_q  <= '0;
      wait_vld_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (overflow)
        err_q <= 1'b1;
      if (join_hit) begin
        pc_q       <= top_pc;
        mask_q     <= top_mask;
        wait_pc_q  <= top_rpc;
        wait_vld_q <= top_rv;
      end else if (accept) begin
        if (!ev_br) begin
          pc_q <= ev_fall;
        end else begin
          unique case (kind)
            BK_UNI_T:  pc_q <= ev_target;
            BK_SPLIT: begin
              if (room2) begin
                pc_q       <= ev_target;
                mask_q     <= t_set;
                wait_pc_q  <= ev_reconv;
                wait_vld_q <= 1'b1;
              end else begin
                pc_q <= ev_fall;
              end
            end
            default:   pc_q <= ev_fall;
          endcase
        end
      end
    end
  end

  assign ev_ready = !join_hit;
  assign pc       = pc_q;
  assign mask     = mask_q;
  assign err      = err_q;
endmodule

// File: rtl/simt_recon_chk.sv
module simt_recon_chk #(
  parameter int  NTHR  = 32,
  parameter int  PCW   = 32,
  parameter int  DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_valid,
  input logic            ev_ready,
  input logic            ev_br,
  input logic [NTHR-1:0] ev_taken,
  input logic [PCW-1:0]  ev_target,
  input logic [PCW-1:0]  ev_fall,
  input logic [PCW-1:0]  pc,
  input logic [NTHR-1:0] mask,
  input logic            err,
  input logic [CW-1:0]   depth
);
  // R2
  plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && !ev_br |=> pc == $past(ev_fall) && mask == $past(mask));

  // R3
  uniform_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_br && ((ev_taken & mask) == mask)
    |=> pc == $past(ev_target) && mask == $past(mask) && depth == $past(depth));

  // R6
  split_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_br && ((ev_taken & mask) != '0) &&
    ((ev_taken & mask) != mask) && (depth <= CW'(DEPTH - 2))
    |=> mask == $past(ev_taken & mask) && pc == $past(ev_target));

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));

  // R11
  pop_one_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ready |=> depth == $past(depth) - CW'(1));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R6
  mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask != '0);
endmodule

bind simt_recon_ctl simt_recon_chk #(.NTHR(NTHR), .PCW(PCW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .ev_br     (ev_br),
  .ev_taken  (ev_taken),
  .ev_target (ev_target),
  .ev_fall   (ev_fall),
  .pc        (pc),
  .mask      (mask),
  .err       (err),
  .depth     (stk_cnt)
);

// File: tb/sim_simt_recon_ctl.sv
`timescale 1ns/1ps
module sim_simt_recon_ctl;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_br = 1'b0;
  logic [31:0] ev_taken = '0, ev_target = '0, ev_fall = '0, ev_reconv = '0;
  logic        ev_ready, err;
  logic [31:0] pc, mask;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  simt_recon_ctl u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_br(ev_br), .ev_taken(ev_taken), .ev_target(ev_target),
    .ev_fall(ev_fall), .ev_reconv(ev_reconv), .pc(pc), .mask(mask), .err(err)
  );

  // behavioural reference: frames kept in queues
  logic [31:0] m_pc, m_mask, m_wpc;
  logic        m_wv, m_err;
  logic [31:0] q_pc[$], q_mask[$], q_rpc[$];
  logic        q_rv[$];

  function automatic bit m_join();
    return m_wv && (m_pc == m_wpc);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 32'h100; m_mask = '1; m_wpc = '0; m_wv = 0; m_err = 0;
      q_pc.delete(); q_mask.delete(); q_rpc.delete(); q_rv.delete();
    end else if (m_join()) begin
      m_pc = q_pc.pop_back(); m_mask = q_mask.pop_back();
      m_wpc = q_rpc.pop_back(); m_wv = q_rv.pop_back();
    end else if (ev_valid) begin
      logic [31:0] t;
      t = ev_taken & m_mask;
      if (!ev_br || t == 0) m_pc = ev_fall;
      else if (t == m_mask) m_pc = ev_target;
      else if (q_pc.size() + 2 > DEPTH) begin
        m_err = 1; m_pc = ev_fall;
      end else begin
        q_pc.push_back(ev_reconv); q_mask.push_back(m_mask);
        q_rpc.push_back(m_wpc);    q_rv.push_back(m_wv);
        q_pc.push_back(ev_fall);   q_mask.push_back(m_mask & ~ev_taken);
        q_rpc.push_back(ev_reconv); q_rv.push_back(1'b1);
        m_pc = ev_target; m_mask = t; m_wpc = ev_reconv; m_wv = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2/R6 model pc", pc, m_pc);
      chk("R7/R8 model mask", mask, m_mask);
      chk("R12 model err", {31'd0, err}, {31'd0, m_err});
      chk("R11 model ready", {31'd0, ev_ready}, {31'd0, !m_join()});
    end
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic send(input logic br, input logic [31:0] tk, tg, fl, rc);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1; ev_br = br; ev_taken = tk; ev_target = tg; ev_fall = fl; ev_reconv = rc;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic step(input logic [31:0] a);
    send(1'b0, '0, '0, a, '0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; ev_valid = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    do_reset();
    // R1
    chk("R1 pc", pc, 32'h100);
    chk("R1 mask", mask, 32'hffff_ffff);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 ready", {31'd0, ev_ready}, 32'd1);

    step(32'h101);
    chk("R2 pc", pc, 32'h101);
    send(1, 32'hffff_ffff, 32'h200, 32'h102, 32'h250);
    chk("R3 pc", pc, 32'h200);
    chk("R3 mask", mask, 32'hffff_ffff);
    send(1, 32'h0, 32'h300, 32'h201, 32'h250);
    chk("R4 pc", pc, 32'h201);

    send(1, 32'h0000_ffff, 32'h400, 32'h202, 32'h500);
    chk("R6 pc", pc, 32'h400);
    chk("R6 mask", mask, 32'h0000_ffff);
    send(1, 32'hffff_00ff, 32'h410, 32'h401, 32'h450);
    chk("R5 mask", mask, 32'h0000_00ff);
    chk("R5 pc", pc, 32'h410);
    step(32'h450);
    chk("R11 ready low", {31'd0, ev_ready}, 32'd0);
    @(negedge clk);
    chk("R7 inner pc", pc, 32'h401);
    chk("R7 inner mask", mask, 32'h0000_ff00);
    step(32'h450);
    @(negedge clk);
    chk("R9 pc", pc, 32'h450);
    chk("R9 mask", mask, 32'h0000_ffff);
    step(32'h500);
    @(negedge clk);
    chk("R7 outer pc", pc, 32'h202);
    chk("R7 outer mask", mask, 32'hffff_0000);
    step(32'h500);
    @(negedge clk);
    chk("R8 pc", pc, 32'h500);
    chk("R8 mask", mask, 32'hffff_ffff);

    // randomized phase with a small address space
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [31:0] tk;
      sel = $urandom % 4;
      tk = (sel == 0) ? 32'hffff_ffff : (sel == 1) ? 32'h0 : $urandom;
      send(sel != 3, tk, 32'($urandom % 16), 32'($urandom % 16), 32'($urandom % 16));
    end
    repeat (20) @(negedge clk);

    // overflow sequence
    do_reset();
    send(1, 32'h0000_ffff, 32'h10, 32'h11, 32'h900);
    send(1, 32'h0000_00ff, 32'h20, 32'h21, 32'h880);
    send(1, 32'h0000_000f, 32'h30, 32'h31, 32'h860);
    send(1, 32'h0000_0003, 32'h40, 32'h41, 32'h840);
    chk("R10 no err at depth 8", {31'd0, err}, 32'd0);
    send(1, 32'h0000_0001, 32'h50, 32'h51, 32'h820);
    chk("R10 err", {31'd0, err}, 32'd1);
    chk("R10 pc", pc, 32'h51);
    chk("R10 mask", mask, 32'h3);
    step(32'h840); @(negedge clk);
    chk("R9 d4 nt mask", mask, 32'hc);
    step(32'h840); @(negedge clk);
    step(32'h860); @(negedge clk);
    chk("R9 d3 nt mask", mask, 32'hf0);
    step(32'h860); @(negedge clk);
    step(32'h880); @(negedge clk);
    step(32'h880); @(negedge clk);
    step(32'h900); @(negedge clk);
    chk("R9 d1 nt pc", pc, 32'h11);
    step(32'h900); @(negedge clk);
    chk("R8 final pc", pc, 32'h900);
    chk("R8 final mask", mask, 32'hffff_ffff);
    chk("R12 err kept", {31'd0, err}, 32'd1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule